// File: doc/BRIEF.md
# Core Event Edge Latch and Pending Tracker

This block sits between a set of general-purpose event lines and the core that services them. Each line passes through a synchroniser and an edge detector. A rising edge sets that line's latch bit. Several sources may share one line, so further edges that arrive while the latch bit is already set merge into it. The block picks the lowest-numbered line whose latch bit is set and whose pending bit is clear, and reports it as the selected event. When the core asserts the accept strobe, that line's pending bit is set and its latch bit is cleared in the same clock edge.

While a line is pending, a new rising edge on it is latched again and waits. The line cannot be selected again until its pending bit clears. A return strobe ends servicing by clearing the lowest-numbered pending bit. The pending word is also the acknowledgement that goes back to the routing logic in front of the lines.

With one synchroniser stage, the shortest path from a rising input to a set pending bit is three core clock cycles.

Top module: `cevt_pend_unit`

## Requirements
- R1: After reset the latch word, the pending word and the select-valid output are all zero.
- R2: A rising level on line i, sampled at clock edge k, sets latch bit i after clock edge k+1. That is two core clock cycles: one synchroniser stage, then a compare against the previous sample.
- R3: Several rising edges on one line with no accept in between leave a single latch bit set. One accept then clears it completely.
- R4: The selected index is the lowest-numbered line whose latch bit is 1 and whose pending bit is 0. On an accept, that line's pending bit is set and its latch bit is cleared at the same edge.
- R5: When accept is held high, the pending bit of a line becomes visible three clock cycles after the input rises.
- R6: A rising edge on a line whose pending bit is set latches again. That line is left out of selection until its pending bit clears.
- R7: A return strobe clears only the lowest-numbered set pending bit.
- R8: An accept strobe with no selectable line changes neither the latch word nor the pending word.
- R9: If a new edge is detected on a line in the same cycle that the line is accepted, its latch bit stays set and its pending bit is set.
- R10: A level held high does not set the latch again, and a falling edge sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_LINES | Raw event lines, asynchronous |
| accept_i | input | 1 | Core takes the selected event |
| ret_i | input | 1 | Core finishes the highest-priority pending event |
| latch_o | output | NUM_LINES | Latched, not yet accepted events |
| pend_o | output | NUM_LINES | Events in service, also the acknowledgement word |
| sel_idx_o | output | IDX_W | Index of the selected line |
| sel_valid_o | output | 1 | A selectable line exists |

## Verification
The bench drives two edges on one line so that the second edge is detected in the same cycle the line is accepted. A design in which the accept clear overrides the new edge would lose that second event. It also re-latches a line that is already pending and then strobes accept. A design that does not mask pending lines would accept that line twice or report it as selectable. The bench measures the input-to-pending delay cycle by cycle, which catches a missing or extra register stage. Finally, a level held high and repeated pulses must each produce exactly one latch, so a level-sensitive or non-merging detector fails.

// File: rtl/cevt_pkg.sv
package cevt_pkg;
   // Width of an index that addresses n lines, never below one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cevt_sync_edge.sv
module cevt_sync_edge #(
   parameter int LINES       = 7,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lvl_i,
   output logic [LINES-1:0] rise_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("cevt_sync_edge: SYNC_STAGES must be at least 1");
   end

   logic [LINES-1:0] stg_q [SYNC_STAGES];
   logic [LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= lvl_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '0;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stg_q[LAST];
   end

   assign rise_o = stg_q[LAST] & ~prev_q;

   // R10
   property rise_needs_low_before;
      @(posedge clk) disable iff (!rst_n) 1'b1 |=> ((rise_o & $past(stg_q[LAST])) == '0);
   endproperty
   rise_prev_low_chk: assert property (rise_needs_low_before);
endmodule

// File: rtl/cevt_prio_pick.sv
module cevt_prio_pick #(
   parameter int LINES = 7,
   parameter int IDX_W = cevt_pkg::idx_width(LINES)
) (
   input  logic [LINES-1:0] req_i,
   output logic [LINES-1:0] onehot_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             valid_o
);
   if (IDX_W < cevt_pkg::idx_width(LINES)) begin : g_bad_width
      $error("cevt_prio_pick: IDX_W too narrow for LINES");
   end

   // Isolate the lowest set request bit.
   assign onehot_o = req_i & (~req_i + LINES'(1));
   assign valid_o  = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   // R4
   pick_onehot_chk: assert final ($onehot0(onehot_o));
endmodule

// File: rtl/cevt_pend_unit.sv
module cevt_pend_unit #(
   parameter int NUM_LINES   = 7,
   parameter int SYNC_STAGES = 1,
   parameter int IDX_W       = cevt_pkg::idx_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] evt_in,
   input  logic                 accept_i,
   input  logic                 ret_i,
   output logic [NUM_LINES-1:0] latch_o,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [IDX_W-1:0]     sel_idx_o,
   output logic                 sel_valid_o
);
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("cevt_pend_unit: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] rise_w;
   logic [NUM_LINES-1:0] latch_q, pend_q;
   logic [NUM_LINES-1:0] cand_w, acc_oh, ret_oh;
   logic [NUM_LINES-1:0] acc_mask, ret_mask;
   logic [IDX_W-1:0]     ret_idx;
   logic                 ret_valid;

   cevt_sync_edge #(.LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (evt_in),
      .rise_o (rise_w)
   );

   assign cand_w = latch_q & ~pend_q;

   cevt_prio_pick #(.LINES(NUM_LINES), .IDX_W(IDX_W)) u_acc_pick (
      .req_i    (cand_w),
      .onehot_o (acc_oh),
      .idx_o    (sel_idx_o),
      .valid_o  (sel_valid_o)
   );

   cevt_prio_pick #(.LINES(NUM_LINES), .IDX_W(IDX_W)) u_ret_pick (
      .req_i    (pend_q),
      .onehot_o (ret_oh),
      .idx_o    (ret_idx),
      .valid_o  (ret_valid)
   );

   assign acc_mask = (accept_i && sel_valid_o) ? acc_oh : '0;
   assign ret_mask = (ret_i && ret_valid)      ? ret_oh : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         pend_q  <= '0;
      end else begin
         // A fresh edge wins over the accept clear so it stays queued.
         latch_q <= (latch_q & ~acc_mask) | rise_w;
         pend_q  <= (pend_q & ~ret_mask) | acc_mask;
      end
   end

   assign latch_o = latch_q;
   assign pend_o  = pend_q;

   // R2
   property latch_rise_from_edge;
      @(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(rise_w)) == '0);
   endproperty
   latch_src_chk: assert property (latch_rise_from_edge);

   // R4
   property accept_sets_pend;
      @(posedge clk) disable iff (!rst_n)
         (accept_i && sel_valid_o) |=> pend_q[$past(sel_idx_o)];
   endproperty
   accept_pend_chk: assert property (accept_sets_pend);

   // R8
   property pend_rise_needs_accept;
      @(posedge clk) disable iff (!rst_n)
         !(accept_i && sel_valid_o) |=> ((pend_q & ~$past(pend_q)) == '0);
   endproperty
   pend_src_chk: assert property (pend_rise_needs_accept);

   // R4
   property single_accept;
      @(posedge clk) disable iff (!rst_n) 1'b1 |=> $onehot0(pend_q & ~$past(pend_q));
   endproperty
   single_acc_chk: assert property (single_accept);

   // R7
   property return_clears_one;
      @(posedge clk) disable iff (!rst_n)
         (ret_i && ret_valid && !accept_i) |=>
            (!pend_q[$past(ret_idx)] &&
             ($countones(pend_q) == $countones($past(pend_q)) - 1));
   endproperty
   ret_one_chk: assert property (return_clears_one);
endmodule

// File: tb/cevt_pend_unit_tb.sv
module cevt_pend_unit_tb;
   localparam int N = 7;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt_in = '0;
   logic         accept_i = 1'b0;
   logic         ret_i = 1'b0;
   logic [N-1:0] latch_o, pend_o;
   logic [W-1:0] sel_idx_o;
   logic         sel_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cevt_pend_unit #(.NUM_LINES(N), .SYNC_STAGES(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .accept_i(accept_i), .ret_i(ret_i),
      .latch_o(latch_o), .pend_o(pend_o), .sel_idx_o(sel_idx_o), .sel_valid_o(sel_valid_o)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_return();
      ret_i = 1'b1; step(); ret_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 latch", 32'(latch_o), 0);
      chk("R1 pend", 32'(pend_o), 0);
      chk("R1 valid", 32'(sel_valid_o), 0);
   endtask

   task automatic t_latency();
      accept_i = 1'b1;
      evt_in[3] = 1'b1;
      step();
      chk("R2 latch not yet", 32'(latch_o), 0);
      step();
      chk("R2 latch set", 32'(latch_o), 32'h08);
      chk("R5 pend not yet", 32'(pend_o), 0);
      step();
      chk("R5 pend at 3", 32'(pend_o), 32'h08);
      chk("R4 latch cleared", 32'(latch_o), 0);
      step(3);
      chk("R10 held level", 32'(latch_o), 0);
      accept_i = 1'b0;
      evt_in[3] = 1'b0;
      step(3);
      chk("R10 falling edge", 32'(latch_o), 0);
      do_return();
      chk("R7 cleared", 32'(pend_o), 0);
   endtask

   task automatic t_priority();
      evt_in[5] = 1'b1; evt_in[2] = 1'b1;
      step(2);
      evt_in[5] = 1'b0; evt_in[2] = 1'b0;
      chk("R4 both latched", 32'(latch_o), 32'h24);
      chk("R4 sel low", 32'(sel_idx_o), 2);
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R4 pend2", 32'(pend_o), 32'h04);
      chk("R4 latch5", 32'(latch_o), 32'h20);
      chk("R4 sel5", 32'(sel_idx_o), 5);
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R4 pend 2,5", 32'(pend_o), 32'h24);
      do_return();
      chk("R7 lowest cleared", 32'(pend_o), 32'h20);
      do_return();
      chk("R7 all cleared", 32'(pend_o), 0);
   endtask

   task automatic t_merge();
      for (int k = 0; k < 3; k++) begin
         evt_in[1] = 1'b1; step();
         evt_in[1] = 1'b0; step();
      end
      step(2);
      chk("R3 one latch", 32'(latch_o), 32'h02);
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R3 pend", 32'(pend_o), 32'h02);
      chk("R3 latch empty", 32'(latch_o), 0);
      chk("R3 no valid", 32'(sel_valid_o), 0);
      do_return();
   endtask

   task automatic t_queue();
      evt_in[0] = 1'b1; step(); evt_in[0] = 1'b0; step();
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R6 pend0", 32'(pend_o), 32'h01);
      evt_in[0] = 1'b1; step(); evt_in[0] = 1'b0; step();
      chk("R6 relatched", 32'(latch_o), 32'h01);
      chk("R6 masked", 32'(sel_valid_o), 0);
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R8 pend kept", 32'(pend_o), 32'h01);
      chk("R8 latch kept", 32'(latch_o), 32'h01);
      do_return();
      chk("R6 selectable", 32'({sel_valid_o, sel_idx_o}), 32'h8);
      accept_i = 1'b1; step(); accept_i = 1'b0;
      chk("R6 second service", 32'({pend_o, latch_o}), 32'h80);
      do_return();
   endtask

   task automatic t_coincide();
      evt_in[6] = 1'b1; step();
      evt_in[6] = 1'b0; step();
      chk("R9 first latch", 32'(latch_o), 32'h40);
      evt_in[6] = 1'b1; step();
      accept_i = 1'b1; step(); accept_i = 1'b0;
      evt_in[6] = 1'b0;
      chk("R9 pend", 32'(pend_o), 32'h40);
      chk("R9 latch kept", 32'(latch_o), 32'h40);
      do_return();
      accept_i = 1'b1; step(); accept_i = 1'b0;
      do_return();
      chk("R9 drained", 32'({pend_o, latch_o}), 0);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_latency();
      t_priority();
      t_merge();
      t_queue();
      t_coincide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule